// File: doc/BRIEF.md
# Performance-State Controller with Thermal Boost

This block chooses the voltage/frequency operating point of a single core. Software names the point it wants from five visible levels. On top of these, the controller can lift the core into one of two faster levels that software cannot select. It does this only when a thermal-credit budget shows spare headroom. Credits build up while the reported power level stays under the design power limit, and they drain while the core is boosted. An empty budget ends the boost.

Each change of operating point is followed by a settle window. During that window no further ordinary change is made. When the window ends, a one-cycle completion pulse is raised. A thermal emergency input works as a failsafe: it drops the core to the slowest level at once, even in the middle of a settle window. The outputs are a state index, a voltage code and a frequency code, which move together.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset the state is index 2 (the fastest visible level), the accepted request is 2, credits are 0, settling and done are low, and the codes are those of index 2.
- R2: State indices and codes: index 0 = boost-high (voltage code 80, frequency code 24), 1 = boost-low (70, 18), 2 (66, 16), 3 (65, 14), 4 (63, 13), 5 (61, 11), 6 = slowest (60, 9). The voltage unit is 12.5 mV and the frequency unit is 100 MHz.
- R3: A request write with an index from 2 to 6 replaces the accepted request on the next edge. A write naming 0, 1 or 7 is rejected and the previous request stays.
- R4: While the state is not a boost state and pwr_level is below PWR_TDP, credits rise by CREDIT_INC per cycle, saturating at CREDIT_MAX. Otherwise, outside boost, they hold.
- R5: While the state is a boost state, credits fall by CREDIT_DEC per cycle, saturating at 0.
- R6: Boost is the target only when boost_en is high, no emergency is present and the accepted request is 2. Entry from a visible state needs credits >= BOOST_ENTRY, and an ongoing boost continues while credits are nonzero. Index 0 is chosen when credits > BOOST_HIGH, and index 1 otherwise.
- R7: When boost is no longer allowed (credits at 0, boost_en low, or a request other than 2), the target falls back to the accepted request.
- R8: With thermal_emerg high at an edge, the state is index 6 after that edge, whether or not a settle window is running.
- R9: A non-emergency change happens on the first edge at which no settle window is running and the target differs from the state. Each change starts a window of SETTLE_CYCLES cycles with settling high, and the state holds through that window.
- R10: done is a one-cycle pulse, high just after the edge that ends a settle window. It is never high together with settling.
- R11: The voltage and frequency codes always match the current state index. They change on the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Request write strobe |
| req_state | input | 3 | Requested state index |
| pwr_level | input | PWR_W | Present power indication |
| thermal_emerg | input | 1 | Thermal emergency flag |
| boost_en | input | 1 | Permits hardware boost |
| cur_state | output | 3 | Current state index |
| volt_code | output | 7 | Voltage code of current state |
| freq_code | output | 5 | Frequency code of current state |
| settling | output | 1 | Settle window running |
| done | output | 1 | Settle completion pulse |
| sw_req | output | 3 | Accepted software request |
| credits | output | clog2(CREDIT_MAX+1) | Thermal credit balance |

## Verification
Every result is registered once. A request write, a credit update, an emergency fall or a state change is therefore visible one edge after the inputs that caused it, and done appears SETTLE_CYCLES edges after the change that opened the window. The bench drives inputs just after a rising edge. It advances a requirement-based model by one cycle per edge and compares all outputs 1 ns after the following edge, so each expectation is sampled in exactly the cycle its register updates. Directed checkpoints after the sweeps confirm credit saturation, boost entry into both tiers, exit when the budget empties, and emergency preemption of a running window.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  localparam int ST_W = 3;
  localparam int VC_W = 7;
  localparam int FC_W = 5;

  typedef enum logic [ST_W-1:0] {
    PS_BHI = 3'd0,
    PS_BLO = 3'd1,
    PS_V0  = 3'd2,
    PS_V1  = 3'd3,
    PS_V2  = 3'd4,
    PS_V3  = 3'd5,
    PS_V4  = 3'd6
  } pstate_e;

  // Voltage in 12.5 mV steps
  function automatic logic [VC_W-1:0] volt_of(logic [ST_W-1:0] s);
    case (s)
      3'd0:    volt_of = 7'd80;
      3'd1:    volt_of = 7'd70;
      3'd2:    volt_of = 7'd66;
      3'd3:    volt_of = 7'd65;
      3'd4:    volt_of = 7'd63;
      3'd5:    volt_of = 7'd61;
      default: volt_of = 7'd60;
    endcase
  endfunction

  // Frequency in 100 MHz steps
  function automatic logic [FC_W-1:0] freq_of(logic [ST_W-1:0] s);
    case (s)
      3'd0:    freq_of = 5'd24;
      3'd1:    freq_of = 5'd18;
      3'd2:    freq_of = 5'd16;
      3'd3:    freq_of = 5'd14;
      3'd4:    freq_of = 5'd13;
      3'd5:    freq_of = 5'd11;
      default: freq_of = 5'd9;
    endcase
  endfunction

  function automatic logic is_boost(logic [ST_W-1:0] s);
    is_boost = (s == PS_BHI) || (s == PS_BLO);
  endfunction

  function automatic logic is_visible(logic [ST_W-1:0] s);
    is_visible = (s >= PS_V0) && (s <= PS_V4);
  endfunction

endpackage

// File: rtl/pstate_req_reg.sv
module pstate_req_reg
  import pstate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_we,
  input  logic [ST_W-1:0] req_state,
  output logic [ST_W-1:0] req_q
);

  logic req_en;

  always_comb begin
    req_en = req_we && is_visible(req_state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= PS_V0;
    end else if (req_en) begin
      req_q <= req_state;
    end
  end

endmodule

// File: rtl/pstate_credit.sv
module pstate_credit
  import pstate_pkg::*;
#(
  parameter int PWR_W      = 8,
  parameter int PWR_TDP    = 100,
  parameter int CREDIT_MAX = 63,
  parameter int CREDIT_INC = 2,
  parameter int CREDIT_DEC = 3,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  cur_state,
  input  logic [PWR_W-1:0] pwr_level,
  output logic [CW-1:0]    cred_q
);

  localparam logic [PWR_W-1:0] TDP_C  = PWR_W'(PWR_TDP);
  localparam logic [CW-1:0]    MAX_C  = CW'(CREDIT_MAX);
  localparam logic [CW-1:0]    INC_C  = CW'(CREDIT_INC);
  localparam logic [CW-1:0]    DEC_C  = CW'(CREDIT_DEC);
  localparam logic [CW-1:0]    ROOM_C = CW'(CREDIT_MAX - CREDIT_INC);

  logic          draining;
  logic          gaining;
  logic          cred_en;
  logic [CW-1:0] cred_d;

  always_comb begin
    draining = is_boost(cur_state);
    gaining  = !draining && (pwr_level < TDP_C);
    cred_en  = draining || gaining;
    cred_d   = cred_q;
    if (draining) begin
      cred_d = (cred_q < DEC_C) ? '0 : (cred_q - DEC_C);
    end else if (gaining) begin
      cred_d = (cred_q > ROOM_C) ? MAX_C : (cred_q + INC_C);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
    end else if (cred_en) begin
      cred_q <= cred_d;
    end
  end

endmodule

// File: rtl/pstate_target.sv
module pstate_target
  import pstate_pkg::*;
#(
  parameter int CREDIT_MAX  = 63,
  parameter int BOOST_ENTRY = 16,
  parameter int BOOST_HIGH  = 40,
  localparam int CW         = $clog2(CREDIT_MAX + 1)
) (
  input  logic [ST_W-1:0] cur_state,
  input  logic [ST_W-1:0] req_q,
  input  logic [CW-1:0]   cred_q,
  input  logic            boost_en,
  input  logic            thermal_emerg,
  output logic [ST_W-1:0] tgt_state
);

  localparam logic [CW-1:0] ENTRY_C = CW'(BOOST_ENTRY);
  localparam logic [CW-1:0] HIGH_C  = CW'(BOOST_HIGH);

  logic budget_ok;
  logic boost_ok;

  always_comb begin
    budget_ok = is_boost(cur_state) ? (cred_q != '0) : (cred_q >= ENTRY_C);
    boost_ok  = boost_en && (req_q == PS_V0) && budget_ok;
    if (thermal_emerg) begin
      tgt_state = PS_V4;
    end else if (boost_ok) begin
      tgt_state = (cred_q > HIGH_C) ? PS_BHI : PS_BLO;
    end else begin
      tgt_state = req_q;
    end
  end

endmodule

// File: rtl/pstate_settle.sv
module pstate_settle
  import pstate_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4,
  localparam int SC_W         = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] tgt_state,
  input  logic            thermal_emerg,
  output logic [ST_W-1:0] cur_q,
  output logic [VC_W-1:0] volt_q,
  output logic [FC_W-1:0] freq_q,
  output logic            busy,
  output logic            done_q
);

  localparam logic [SC_W-1:0] LOAD_C = SC_W'(SETTLE_CYCLES);
  localparam logic [SC_W-1:0] ONE_C  = SC_W'(1);

  logic [SC_W-1:0] cnt_q;
  logic [SC_W-1:0] cnt_d;
  logic            cnt_en;
  logic            take;
  logic            forced;
  logic            done_d;

  always_comb begin
    busy   = (cnt_q != '0);
    forced = thermal_emerg && (cur_q != PS_V4);
    take   = forced || (!busy && (tgt_state != cur_q));
    cnt_en = take || busy;
    cnt_d  = take ? LOAD_C : (cnt_q - ONE_C);
    done_d = !take && (cnt_q == ONE_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= PS_V0;
      volt_q <= volt_of(PS_V0);
      freq_q <= freq_of(PS_V0);
    end else if (take) begin
      cur_q  <= tgt_state;
      volt_q <= volt_of(tgt_state);
      freq_q <= freq_of(tgt_state);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int PWR_W         = 8,
  parameter int PWR_TDP       = 100,
  parameter int CREDIT_MAX    = 63,
  parameter int CREDIT_INC    = 2,
  parameter int CREDIT_DEC    = 3,
  parameter int BOOST_ENTRY   = 16,
  parameter int BOOST_HIGH    = 40,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_we,
  input  logic [2:0]                        req_state,
  input  logic [PWR_W-1:0]                  pwr_level,
  input  logic                              thermal_emerg,
  input  logic                              boost_en,
  output logic [2:0]                        cur_state,
  output logic [6:0]                        volt_code,
  output logic [4:0]                        freq_code,
  output logic                              settling,
  output logic                              done,
  output logic [2:0]                        sw_req,
  output logic [$clog2(CREDIT_MAX+1)-1:0]   credits
);

  logic [ST_W-1:0] tgt_state;

  pstate_req_reg u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_we    (req_we),
    .req_state (req_state),
    .req_q     (sw_req)
  );

  pstate_credit #(
    .PWR_W      (PWR_W),
    .PWR_TDP    (PWR_TDP),
    .CREDIT_MAX (CREDIT_MAX),
    .CREDIT_INC (CREDIT_INC),
    .CREDIT_DEC (CREDIT_DEC)
  ) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_state (cur_state),
    .pwr_level (pwr_level),
    .cred_q    (credits)
  );

  pstate_target #(
    .CREDIT_MAX  (CREDIT_MAX),
    .BOOST_ENTRY (BOOST_ENTRY),
    .BOOST_HIGH  (BOOST_HIGH)
  ) u_target (
    .cur_state     (cur_state),
    .req_q         (sw_req),
    .cred_q        (credits),
    .boost_en      (boost_en),
    .thermal_emerg (thermal_emerg),
    .tgt_state     (tgt_state)
  );

  pstate_settle #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk           (clk),
    .rst_n         (rst_n),
    .tgt_state     (tgt_state),
    .thermal_emerg (thermal_emerg),
    .cur_q         (cur_state),
    .volt_q        (volt_code),
    .freq_q        (freq_code),
    .busy          (settling),
    .done_q        (done)
  );

endmodule

// File: rtl/pstate_ctrl_chk.sv
module pstate_ctrl_chk
  import pstate_pkg::*;
#(
  parameter int CREDIT_MAX = 63,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          thermal_emerg,
  input logic [2:0]    cur_state,
  input logic [6:0]    volt_code,
  input logic [4:0]    freq_code,
  input logic          settling,
  input logic          done,
  input logic [2:0]    sw_req,
  input logic [CW-1:0] credits
);

  a_r3_req_visible: assert property (@(posedge clk) disable iff (!rst_n)
    is_visible(sw_req));

  a_r4_credit_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CW'(CREDIT_MAX));

  a_r8_emerg_floor: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_emerg |=> (cur_state == PS_V4));

  a_r9_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && !thermal_emerg) |=> $stable(cur_state));

  a_r10_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !settling);

  a_r11_codes_track: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_code == volt_of(cur_state)) && (freq_code == freq_of(cur_state)));

endmodule

bind pstate_ctrl pstate_ctrl_chk #(.CREDIT_MAX(CREDIT_MAX)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .thermal_emerg (thermal_emerg),
  .cur_state     (cur_state),
  .volt_code     (volt_code),
  .freq_code     (freq_code),
  .settling      (settling),
  .done          (done),
  .sw_req        (sw_req),
  .credits       (credits)
);

// File: tb/pstate_ctrl_tb.sv
`timescale 1ns/1ps
module pstate_ctrl_tb_top;

  localparam int P_W   = 8;
  localparam int TDP   = 50;
  localparam int CMAX  = 20;
  localparam int CINC  = 2;
  localparam int CDEC  = 3;
  localparam int ENTRY = 8;
  localparam int HIGH  = 14;
  localparam int SETL  = 3;
  localparam int CW    = $clog2(CMAX + 1);

  logic           clk;
  logic           rst_n;
  logic           req_we;
  logic [2:0]     req_state;
  logic [P_W-1:0] pwr_level;
  logic           thermal_emerg;
  logic           boost_en;
  logic [2:0]     cur_state;
  logic [6:0]     volt_code;
  logic [4:0]     freq_code;
  logic           settling;
  logic           done;
  logic [2:0]     sw_req;
  logic [CW-1:0]  credits;

  pstate_ctrl #(
    .PWR_W(P_W), .PWR_TDP(TDP), .CREDIT_MAX(CMAX), .CREDIT_INC(CINC),
    .CREDIT_DEC(CDEC), .BOOST_ENTRY(ENTRY), .BOOST_HIGH(HIGH),
    .SETTLE_CYCLES(SETL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_state(req_state),
    .pwr_level(pwr_level), .thermal_emerg(thermal_emerg), .boost_en(boost_en),
    .cur_state(cur_state), .volt_code(volt_code), .freq_code(freq_code),
    .settling(settling), .done(done), .sw_req(sw_req), .credits(credits)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // expected codes per state index (R2)
  int exp_v [7] = '{80, 70, 66, 65, 63, 61, 60};
  int exp_f [7] = '{24, 18, 16, 14, 13, 11, 9};

  // model state
  int m_cur, m_cnt, m_cred, m_req, m_done;
  bit seen [7];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int tgt, n_cur, n_cnt, n_cred, n_req, n_done;
    bool_blk: begin
      bit boosting, ok;
      boosting = (m_cur <= 1);
      ok = boost_en && (m_req == 2) && (boosting ? (m_cred != 0) : (m_cred >= ENTRY));
      if (thermal_emerg) tgt = 6;
      else if (ok) tgt = (m_cred > HIGH) ? 0 : 1;
      else tgt = m_req;
      n_cred = m_cred;
      if (boosting) n_cred = (m_cred < CDEC) ? 0 : m_cred - CDEC;
      else if (pwr_level < TDP) n_cred = (m_cred + CINC > CMAX) ? CMAX : m_cred + CINC;
    end
    n_req = (req_we && req_state >= 2 && req_state <= 6) ? int'(req_state) : m_req;
    n_cur = m_cur; n_cnt = m_cnt; n_done = 0;
    if ((thermal_emerg && m_cur != 6) || (m_cnt == 0 && tgt != m_cur)) begin
      n_cur = tgt; n_cnt = SETL;
    end else if (m_cnt != 0) begin
      n_cnt = m_cnt - 1; n_done = (m_cnt == 1);
    end
    @(posedge clk);
    #1;
    m_cur = n_cur; m_cnt = n_cnt; m_cred = n_cred; m_req = n_req; m_done = n_done;
    seen[m_cur] = 1'b1;
    check("R9 state", int'(cur_state), m_cur);
    check((m_cur <= 1) ? "R5 credits" : "R4 credits", int'(credits), m_cred);
    check("R3 request", int'(sw_req), m_req);
    check("R10 done", int'(done), m_done);
    check("R10 settling", int'(settling), int'(m_cnt != 0));
    check("R11 voltage", int'(volt_code), exp_v[m_cur]);
    check("R11 frequency", int'(freq_code), exp_f[m_cur]);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_req(int s);
    req_we = 1'b1; req_state = 3'(s);
    step();
    req_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_we = 1'b0; req_state = 3'd0; pwr_level = 8'd60;
    thermal_emerg = 1'b0; boost_en = 1'b0;
    m_cur = 2; m_cnt = 0; m_cred = 0; m_req = 2; m_done = 0;
    seen[2] = 1'b1;
    #23;
    // R1 reset state
    check("R1 state", int'(cur_state), 2);
    check("R1 credits", int'(credits), 0);
    check("R1 request", int'(sw_req), 2);
    check("R1 settling", int'(settling), 0);
    check("R1 done", int'(done), 0);
    check("R1 voltage", int'(volt_code), 66);
    check("R1 frequency", int'(freq_code), 16);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 sweep of every request code, visible and rejected
    for (int s = 7; s >= 0; s--) begin
      write_req(s);
      run(5);
    end
    write_req(2);
    run(5);
    check("R3 boost index rejected, request kept", int'(sw_req), 2);

    // R4 build credits to saturation
    pwr_level = 8'd10;
    run(14);
    check("R4 credit saturation", int'(credits), CMAX);

    // R6 boost entry then R5 drain and R7 exit on empty budget
    pwr_level = 8'd60;
    boost_en = 1'b1;
    step();
    check("R6 boost-high entered", int'(cur_state), 0);
    run(24);
    check("R7 back to request after budget empty", int'(cur_state), 2);
    check("R5 credit floor", int'(credits), 0);

    // R7 exit when boost_en drops
    pwr_level = 8'd10;
    run(8);
    check("R6 boost-low entered", int'(cur_state), 1);
    boost_en = 1'b0;
    run(SETL + 2);
    check("R7 exit on disable", int'(cur_state), 2);

    // R6 no boost while a slower level is requested
    boost_en = 1'b1;
    write_req(4);
    run(12);
    check("R6 no boost off top request", int'(cur_state), 4);

    // R8 emergency preempts a running settle window
    write_req(3);
    step();
    thermal_emerg = 1'b1;
    step();
    check("R8 emergency floor", int'(cur_state), 6);
    run(6);
    thermal_emerg = 1'b0;
    write_req(2);
    run(16);
    thermal_emerg = 1'b1;
    step();
    check("R8 emergency out of boost", int'(cur_state), 6);
    thermal_emerg = 1'b0;
    boost_en = 1'b0;
    run(10);

    // R2 every index visited with its codes
    for (int i = 0; i < 7; i++) check("R2 state visited", int'(seen[i]), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule